// File: doc/BRIEF.md
# Integer ALU with Condition Flags and Branch Decision

This block is a 32-bit integer execution slice for a simple processor datapath. Each cycle it takes two operands and an operation code. It produces a registered result and a registered write strobe for that result. It also computes four condition flags: zero, sign, unsigned carry/borrow and signed overflow. The flags are loaded into a flag register only when the flag-update input is high in that cycle.

A separate 4-bit condition selector is decoded against the held flags to produce a branch-taken decision. The selector covers the following conditions:
- always
- equal and not equal
- negative and non-negative
- four signed orderings
- two unsigned orderings

The branch path is combinational from the flag register and the selector. A sequencer can therefore issue a compare in one cycle and resolve the branch in the next.

The compare and test operations exist only to set flags. They never write the result. Test also forces the carry and overflow flags to zero.

Top module: `flag_branch_alu`

## Requirements
- R1: On a flag update, `zf` becomes 1 exactly when the DATA_W-bit value computed by the operation is zero.
- R2: On a flag update, `sf` becomes the most significant bit of the computed value.
- R3: Add (op 0) computes a+b. On a flag update, `cf` becomes the carry out and `ovf` becomes the signed overflow. Subtract (op 1) computes a-b. On a flag update, `cf` becomes 1 when a is unsigned-less-than b (a borrow occurs) and `ovf` becomes the signed overflow.
- R4: Compare (op 0x5) sets all four flags exactly as subtract does. It leaves `result_we` low in the following cycle and leaves `result` unchanged.
- R5: Test (op 0x6) sets `zf` and `sf` from a AND b and clears `cf` and `ovf`. It leaves `result_we` low in the following cycle and leaves `result` unchanged.
- R6: AND (op 2), OR (op 3) and XOR (op 4) write their bitwise result. On a flag update they clear `cf` and `ovf`.
- R7: For ops 0 to 4, `result` and `result_we`=1 appear one clock after the operands are presented. For any other op, `result_we` is 0 one clock later and `result` keeps its previous value.
- R8: The flags change only at a clock edge where `flags_we` is 1. When `flags_we` is 0, all four flags keep their values.
- R9: `branch_taken` is evaluated combinationally from the registered flags. Selector codes 0 to 4 give, in order: always, ZF, not ZF, SF, not SF.
- R10: Selector codes 5 to 8 give, in order:
  - greater: not(SF xor OF) and not ZF
  - greater-or-equal: not(SF xor OF)
  - less: SF xor OF
  - less-or-equal: (SF xor OF) or ZF
- R11: Selector code 9 gives not CF and not ZF, and code 10 gives CF. Codes 11 to 15 always give not-taken.
- R12: Op code 7 is reserved. It writes no result and changes no flag, even when `flags_we` is 1.
- R13: Synchronous active-high reset clears `result`, `result_we` and all four flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opnd_a | input | DATA_W | First operand |
| opnd_b | input | DATA_W | Second operand |
| op_code | input | 3 | Operation select (see requirements) |
| flags_we | input | 1 | Load the computed flags at this edge |
| cond_sel | input | 4 | Branch condition selector |
| result | output | DATA_W | Registered result of the last writing operation |
| result_we | output | 1 | Registered: the previous cycle's op wrote the result |
| zf | output | 1 | Zero flag |
| sf | output | 1 | Sign flag |
| cf | output | 1 | Carry / borrow flag |
| ovf | output | 1 | Signed overflow flag |
| branch_taken | output | 1 | Selected condition holds on the registered flags |

## Verification
A wrong flag register value shows up on the flag outputs one clock after the operation. Within the same cycle it also shows up as a wrong `branch_taken` for every selector that depends on that flag. Sweeping all sixteen selector codes against each flag state exposes any decode error in the cycle the flags settle.

A wrongly held or overwritten result shows up at `result` in the cycle after a compare, test or reserved op. A missed `flags_we` gating shows up as a flag that moves when it should have stayed. The bench runs every operand pair of a 4-bit configuration through all eight op codes, with the flag update enabled on most but not all steps, so both of these faults are exposed.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;

  localparam int OP_W  = 3;
  localparam int SEL_W = 4;
  localparam int NCOND = 11;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4,
    OP_CMP = 3'd5,
    OP_TST = 3'd6,
    OP_RSV = 3'd7
  } alu_op_e;

  typedef enum logic [SEL_W-1:0] {
    CC_ALW  = 4'd0,
    CC_EQ   = 4'd1,
    CC_NE   = 4'd2,
    CC_NEG  = 4'd3,
    CC_NNEG = 4'd4,
    CC_GT   = 4'd5,
    CC_GE   = 4'd6,
    CC_LT   = 4'd7,
    CC_LE   = 4'd8,
    CC_ABV  = 4'd9,
    CC_BLW  = 4'd10
  } cc_sel_e;

  typedef struct packed {
    logic z;
    logic s;
    logic c;
    logic v;
  } cc_flags_t;

endpackage

// File: rtl/alu_cc_exec.sv
module alu_cc_exec
  import alu_cc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [OP_W-1:0] op,
  output logic [W-1:0]    val,
  output logic            wr,
  output logic            upd_ok,
  output cc_flags_t       nxt
);

  localparam int MSB = W - 1;

  logic [W:0]   sum_ext;
  logic [W:0]   dif_ext;
  logic [W-1:0] and_v;
  logic         add_ov;
  logic         sub_ov;

  always_comb begin
    sum_ext = {1'b0, a} + {1'b0, b};
    dif_ext = {1'b0, a} - {1'b0, b};
    and_v   = a & b;
    add_ov  = (a[MSB] == b[MSB]) && (sum_ext[MSB] != a[MSB]);
    sub_ov  = (a[MSB] != b[MSB]) && (dif_ext[MSB] != a[MSB]);
  end

  always_comb begin
    val    = '0;
    wr     = 1'b0;
    upd_ok = 1'b1;
    nxt.c  = 1'b0;
    nxt.v  = 1'b0;
    unique case (alu_op_e'(op))
      OP_ADD: begin
        val   = sum_ext[W-1:0];
        wr    = 1'b1;
        nxt.c = sum_ext[W];
        nxt.v = add_ov;
      end
      OP_SUB: begin
        val   = dif_ext[W-1:0];
        wr    = 1'b1;
        nxt.c = dif_ext[W];
        nxt.v = sub_ov;
      end
      OP_AND: begin
        val = and_v;
        wr  = 1'b1;
      end
      OP_OR: begin
        val = a | b;
        wr  = 1'b1;
      end
      OP_XOR: begin
        val = a ^ b;
        wr  = 1'b1;
      end
      OP_CMP: begin
        val   = dif_ext[W-1:0];
        nxt.c = dif_ext[W];
        nxt.v = sub_ov;
      end
      OP_TST: begin
        val = and_v;
      end
      default: begin
        upd_ok = 1'b0;
      end
    endcase
    nxt.z = ~|val;
    nxt.s = val[MSB];
  end

endmodule

// File: rtl/alu_cc_flagreg.sv
module alu_cc_flagreg
  import alu_cc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      we,
  input  cc_flags_t d,
  output cc_flags_t q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (we) begin
      q <= d;
    end
  end

endmodule

// File: rtl/alu_cc_cond.sv
module alu_cc_cond
  import alu_cc_pkg::*;
(
  input  cc_flags_t        fl,
  input  logic [SEL_W-1:0] sel,
  output logic             taken
);

  localparam int NSEL = 1 << SEL_W;

  logic [NCOND-1:0] hit;
  logic [NSEL-1:0]  table_v;
  logic             lt_s;

  always_comb begin
    lt_s         = fl.s ^ fl.v;
    hit          = '0;
    hit[CC_ALW]  = 1'b1;
    hit[CC_EQ]   = fl.z;
    hit[CC_NE]   = ~fl.z;
    hit[CC_NEG]  = fl.s;
    hit[CC_NNEG] = ~fl.s;
    hit[CC_GT]   = ~lt_s & ~fl.z;
    hit[CC_GE]   = ~lt_s;
    hit[CC_LT]   = lt_s;
    hit[CC_LE]   = lt_s | fl.z;
    hit[CC_ABV]  = ~fl.c & ~fl.z;
    hit[CC_BLW]  = fl.c;
  end

  for (genvar gi = 0; gi < NSEL; gi++) begin : g_sel
    if (gi < NCOND) begin : g_used
      assign table_v[gi] = hit[gi];
    end else begin : g_unused
      assign table_v[gi] = 1'b0;
    end
  end

  assign taken = table_v[sel];

endmodule

// File: rtl/flag_branch_alu.sv
module flag_branch_alu
  import alu_cc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [2:0]        op_code,
  input  logic              flags_we,
  input  logic [3:0]        cond_sel,
  output logic [DATA_W-1:0] result,
  output logic              result_we,
  output logic              zf,
  output logic              sf,
  output logic              cf,
  output logic              ovf,
  output logic              branch_taken
);

  logic [DATA_W-1:0] ex_val;
  logic              ex_wr;
  logic              ex_upd;
  cc_flags_t         ex_fl;
  cc_flags_t         fl_q;

  alu_cc_exec #(.W(DATA_W)) u_exec (
    .a      (opnd_a),
    .b      (opnd_b),
    .op     (op_code),
    .val    (ex_val),
    .wr     (ex_wr),
    .upd_ok (ex_upd),
    .nxt    (ex_fl)
  );

  alu_cc_flagreg u_flags (
    .clk (clk),
    .rst (rst),
    .we  (flags_we & ex_upd),
    .d   (ex_fl),
    .q   (fl_q)
  );

  alu_cc_cond u_cond (
    .fl    (fl_q),
    .sel   (cond_sel),
    .taken (branch_taken)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      result_we <= 1'b0;
    end else begin
      result_we <= ex_wr;
      if (ex_wr) begin
        result <= ex_val;
      end
    end
  end

  assign zf  = fl_q.z;
  assign sf  = fl_q.s;
  assign cf  = fl_q.c;
  assign ovf = fl_q.v;

endmodule

// File: rtl/flag_branch_alu_chk.sv
module flag_branch_alu_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        op_code,
  input logic              flags_we,
  input logic [3:0]        cond_sel,
  input logic [DATA_W-1:0] result,
  input logic              result_we,
  input logic              zf,
  input logic              sf,
  input logic              cf,
  input logic              ovf,
  input logic              branch_taken
);

  // R1: zero flag agrees with a freshly written result
  a_r1_zero_matches: assert property (@(posedge clk) disable iff (rst)
    (flags_we && op_code <= 3'd4) |=> (zf == (result == '0)));

  // R2: sign flag agrees with a freshly written result
  a_r2_sign_matches: assert property (@(posedge clk) disable iff (rst)
    (flags_we && op_code <= 3'd4) |=> (sf == result[DATA_W-1]));

  // R4: compare never writes
  a_r4_cmp_no_write: assert property (@(posedge clk) disable iff (rst)
    (op_code == 3'd5) |=> (!result_we && $stable(result)));

  // R5: test clears carry and overflow and never writes
  a_r5_test_clears: assert property (@(posedge clk) disable iff (rst)
    (flags_we && op_code == 3'd6) |=> (!cf && !ovf && !result_we && $stable(result)));

  // R6: logic ops clear carry and overflow
  a_r6_logic_clears: assert property (@(posedge clk) disable iff (rst)
    (flags_we && (op_code == 3'd2 || op_code == 3'd3 || op_code == 3'd4)) |=> (!cf && !ovf));

  // R7: writing ops raise the write strobe one cycle later
  a_r7_write_strobe: assert property (@(posedge clk) disable iff (rst)
    (op_code <= 3'd4) |=> result_we);

  // R8: flags hold without the update enable
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !flags_we |=> ($stable(zf) && $stable(sf) && $stable(cf) && $stable(ovf)));

  // R9: the always condition is taken
  a_r9_always: assert property (@(posedge clk) disable iff (rst)
    (cond_sel == 4'd0) |-> branch_taken);

  // R11: unused selector codes are never taken
  a_r11_unused: assert property (@(posedge clk) disable iff (rst)
    (cond_sel > 4'd10) |-> !branch_taken);

  // R12: reserved op changes nothing
  a_r12_reserved: assert property (@(posedge clk) disable iff (rst)
    (op_code == 3'd7) |=> (!result_we && $stable(result) && $stable(zf) &&
                           $stable(sf) && $stable(cf) && $stable(ovf)));

endmodule

bind flag_branch_alu flag_branch_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .op_code      (op_code),
  .flags_we     (flags_we),
  .cond_sel     (cond_sel),
  .result       (result),
  .result_we    (result_we),
  .zf           (zf),
  .sf           (sf),
  .cf           (cf),
  .ovf          (ovf),
  .branch_taken (branch_taken)
);

// File: tb/flag_branch_alu_bench.sv
`timescale 1ns/100ps
module flag_branch_alu_bench;

  localparam int W    = 4;
  localparam int MAXU = 1 << W;
  localparam int HALF = 1 << (W - 1);

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opnd_a = '0;
  logic [W-1:0] opnd_b = '0;
  logic [2:0]   op_code = 3'd7;
  logic         flags_we = 1'b0;
  logic [3:0]   cond_sel = 4'd0;
  logic [W-1:0] result;
  logic         result_we;
  logic         zf, sf, cf, ovf, branch_taken;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  flag_branch_alu #(.DATA_W(W)) u_flag_branch_alu (
    .clk          (clk),
    .rst          (rst),
    .opnd_a       (opnd_a),
    .opnd_b       (opnd_b),
    .op_code      (op_code),
    .flags_we     (flags_we),
    .cond_sel     (cond_sel),
    .result       (result),
    .result_we    (result_we),
    .zf           (zf),
    .sf           (sf),
    .cf           (cf),
    .ovf          (ovf),
    .branch_taken (branch_taken)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sgn(input int u);
    return (u >= HALF) ? u - MAXU : u;
  endfunction

  function automatic bit br_exp(input int sel, input bit z, input bit s, input bit c, input bit v);
    case (sel)
      0:  return 1'b1;
      1:  return z;
      2:  return !z;
      3:  return s;
      4:  return !s;
      5:  return !(s ^ v) && !z;
      6:  return !(s ^ v);
      7:  return s ^ v;
      8:  return (s ^ v) || z;
      9:  return !c && !z;
      10: return c;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check_branches(input bit z, input bit s, input bit c, input bit v);
    for (int k = 0; k < 16; k++) begin
      cond_sel = 4'(k);
      #0.5;
      chk(branch_taken == br_exp(k, z, s, c, v),
          (k <= 4) ? "R9" : (k <= 8) ? "R10" : "R11",
          branch_taken, br_exp(k, z, s, c, v));
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R13: reset state
    chk(result == '0, "R13", result, 0);
    chk(result_we == 1'b0, "R13", result_we, 0);
    chk({zf, sf, cf, ovf} == 4'b0, "R13", {zf, sf, cf, ovf}, 0);
    check_branches(0, 0, 0, 0);
    @(negedge clk);
    begin
      int e_res = 0;
      bit ez = 0, es = 0, ec = 0, ev = 0;
      for (int op = 0; op < 8; op++) begin
        for (int a = 0; a < MAXU; a++) begin
          for (int b = 0; b < MAXU; b++) begin
            int val, full, sv;
            bit wr, upd, nc, nv;
            bit fwe;
            string tg;
            fwe = ((a + 3 * b + op) % 7) != 0;
            nc = 0;
            nv = 0;
            upd = 1;
            wr = (op <= 4);
            sv = 0;
            case (op)
              0: begin full = a + b; val = full % MAXU; nc = full >= MAXU;
                   sv = sgn(a) + sgn(b); nv = (sv >= HALF) || (sv < -HALF); end
              1, 5: begin val = (a - b + MAXU) % MAXU; nc = a < b;
                   sv = sgn(a) - sgn(b); nv = (sv >= HALF) || (sv < -HALF); end
              2, 6: val = a & b;
              3: val = a | b;
              4: val = a ^ b;
              default: begin val = 0; upd = 0; end
            endcase
            case (op)
              0, 1: tg = "R3";
              5: tg = "R4";
              6: tg = "R5";
              7: tg = "R12";
              default: tg = "R6";
            endcase
            opnd_a = W'(a);
            opnd_b = W'(b);
            op_code = 3'(op);
            flags_we = fwe;
            @(posedge clk);
            #1;
            if (wr) e_res = val;
            if (fwe && upd) begin
              ez = (val == 0);
              es = (val >= HALF);
              ec = nc;
              ev = nv;
            end
            chk(result_we == wr, wr ? "R7" : tg, result_we, wr);
            chk(result == W'(e_res), wr ? "R7" : tg, result, e_res);
            chk(zf == ez, fwe ? "R1" : "R8", zf, ez);
            chk(sf == es, fwe ? "R2" : "R8", sf, es);
            chk(cf == ec, fwe ? tg : "R8", cf, ec);
            chk(ovf == ev, fwe ? tg : "R8", ovf, ev);
            if (((a + b) % 5) == 0) check_branches(ez, es, ec, ev);
            @(negedge clk);
          end
        end
      end
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule